// File: doc/BRIEF.md
# SMBus Host Register Front-End

This block is the register file that software sees on an SMBus host controller. It is reached through a simple I/O strobe interface with 16-bit data. It holds the following state:

- a status word whose error and completion flags are sticky;
- a control word carrying the cycle type, the start request, the abort request and the interrupt enable;
- the target address, data and command registers;
- a byte FIFO that stages the payload of block transfers.

A start that software writes while the controller is idle becomes a one-cycle start pulse to a separate transaction engine. The engine reads the cycle type, address, command and data from dedicated outputs. When the engine reports completion, the block drops the busy flag, raises cycle-complete and captures the engine's error flags, all in the same edge.

For a block write, software writes the byte count into the data register while idle, which also empties the FIFO. It then pushes the payload through the FIFO port, and the engine pops it. For a block read, the engine pushes the received bytes and stores the received length in the data register. Software then reads the length and pops each byte through the FIFO port. The serial protocol timing itself lives in the engine, not here.

Top module: `smbh_regfront`

## Requirements
- R1: After reset the status word, control word, address, command and data registers read as 0, the FIFO is empty, and eng_start, eng_abort and irq are low.
- R2: Offsets decode as follows: status 0x00, control 0x02, address 0x04, data 0x06, command 0x08, FIFO port 0x09. Address, command and data read back what was written and appear unchanged on eng_addr, eng_cmd and eng_data. In the address register, bit 0 is the direction (1 = read) and bits 7:1 are the target.
- R3: A control write with bit 3 set while status bit 3 (busy) is 0 sets busy and produces a one-cycle eng_start in the next cycle. Control bits 2:0 (cycle type) drive eng_cycle, and bit 4 is the interrupt enable. The start bit (3) and the abort bit (5) always read back as 0.
- R4: A start written while busy produces no eng_start and leaves busy set.
- R5: eng_done while busy clears busy and sets status bit 4 (cycle complete) in the same edge. It also ORs eng_err into the status word: eng_err[3] goes to bit 5 (timeout), eng_err[2] to bit 2 (protocol error), eng_err[1] to bit 1 (collision/no-ack) and eng_err[0] to bit 0 (aborted).
- R6: Writing 1 to status bits 5, 4, 2, 1 or 0 clears those bits, and writing 0 leaves them. Busy (bit 3) is never cleared by a status write.
- R7: Control bit 5 written while busy produces a one-cycle eng_abort in the next cycle. Written while idle, it produces none.
- R8: irq is high exactly when status bit 4 and control bit 4 are both 1.
- R9: A data register write while idle empties the FIFO; written while busy, it leaves the FIFO untouched. Bytes written to offset 0x09 and bytes pushed by the engine leave in the order they entered. eng_fifo_head shows the oldest byte, and eng_fifo_pop removes it.
- R10: Pushes into a full FIFO (32 entries) are dropped. A pop from an empty FIFO changes nothing, and both offset 0x09 and eng_fifo_head read 0x00 when the FIFO is empty.
- R11: eng_done with eng_data_we loads eng_data_in into the data register. Software can then read the received length at 0x06 and pop the engine's bytes in order by reading 0x09.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe (pops the FIFO at 0x09) |
| io_addr | input | ADDR_W | Host register offset |
| io_wdata | input | 16 | Host write data |
| io_rdata | output | 16 | Host read data, combinational from io_addr |
| irq | output | 1 | Cycle-complete interrupt |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_abort | output | 1 | One-cycle abort pulse to the engine |
| eng_cycle | output | 3 | Selected cycle type |
| eng_addr | output | 8 | Target address with direction bit |
| eng_cmd | output | 8 | Command byte |
| eng_data | output | 16 | Data register / block count |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 4 | Engine error flags: timeout, protocol, collision, aborted |
| eng_data_we | input | 1 | With eng_done, load eng_data_in into data |
| eng_data_in | input | 16 | Result word or received length |
| eng_fifo_pop | input | 1 | Engine removes the oldest FIFO byte |
| eng_fifo_head | output | 8 | Oldest FIFO byte, 0 when empty |
| eng_fifo_push | input | 1 | Engine appends a received byte |
| eng_fifo_wdata | input | 8 | Byte appended by the engine |

## Verification
The start path is tried from idle, again while busy, and together with an abort. This tells a start that is accepted apart from one that is swallowed, and an abort that is forwarded apart from one dropped while idle. Completion is driven with several error patterns (none, collision with abort, timeout with protocol error), followed by partial and full write-one-to-clear masks. This separates set-wins capture from clearing and shows that busy survives a clear. The FIFO is driven by host pushes with engine pops, by engine pushes with host pops, past its capacity, and while empty. This exposes ordering, overflow, empty-read value and the idle-only pointer reset.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
   // register offsets (software-visible decode)
   localparam int OFF_STS  = 'h0;
   localparam int OFF_CTL  = 'h2;
   localparam int OFF_ADR  = 'h4;
   localparam int OFF_DAT  = 'h6;
   localparam int OFF_CMD  = 'h8;
   localparam int OFF_FIFO = 'h9;

   // status bit positions
   localparam int ST_TMO  = 5;
   localparam int ST_DONE = 4;
   localparam int ST_BUSY = 3;
   localparam int ST_PROT = 2;
   localparam int ST_COL  = 1;
   localparam int ST_ABRT = 0;
   localparam logic [5:0] ST_W1C_MASK = 6'b11_0111;

   // control bit positions
   localparam int CT_ABORT = 5;
   localparam int CT_IEN   = 4;
   localparam int CT_START = 3;

   typedef struct packed {
      logic tmo;
      logic prot;
      logic col;
      logic abrt;
   } smbh_err_t;
endpackage

// File: rtl/smbh_status.sv
module smbh_status
   import smbh_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sts_we,
   input  logic [5:0] sts_wdata,
   input  logic       start_req,
   input  logic       abort_req,
   input  logic       done,
   input  smbh_err_t  err,
   output logic       busy,
   output logic [5:0] sts,
   output logic       start_p,
   output logic       abort_p
);
   logic [5:0] flags_q, flags_n;
   logic       start_ok, abort_ok, done_ok;

   assign start_ok = start_req & ~busy;
   assign abort_ok = abort_req & busy;
   assign done_ok  = done & busy;

   always_comb begin
      flags_n = flags_q;
      if (sts_we) flags_n = flags_n & ~(sts_wdata & ST_W1C_MASK);
      if (done_ok) begin
         flags_n[ST_DONE] = 1'b1;
         flags_n[ST_TMO]  = flags_n[ST_TMO]  | err.tmo;
         flags_n[ST_PROT] = flags_n[ST_PROT] | err.prot;
         flags_n[ST_COL]  = flags_n[ST_COL]  | err.col;
         flags_n[ST_ABRT] = flags_n[ST_ABRT] | err.abrt;
      end
      flags_n[ST_BUSY] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         busy    <= 1'b0;
         start_p <= 1'b0;
         abort_p <= 1'b0;
      end else begin
         flags_q <= flags_n;
         start_p <= start_ok;
         abort_p <= abort_ok;
         if (start_ok)     busy <= 1'b1;
         else if (done_ok) busy <= 1'b0;
      end
   end

   always_comb begin
      sts          = flags_q;
      sts[ST_BUSY] = busy;
   end
endmodule

// File: rtl/smbh_hregs.sv
module smbh_hregs
   import smbh_pkg::*;
#(
   parameter int DATA_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_ctl,
   input  logic              we_adr,
   input  logic              we_dat,
   input  logic              we_cmd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   input  logic              eng_load,
   input  logic [DATA_W-1:0] eng_word,
   output logic [2:0]        cyc,
   output logic              ien,
   output logic [7:0]        adr,
   output logic [7:0]        cmd,
   output logic [DATA_W-1:0] dat,
   output logic              fifo_clr
);
   assign fifo_clr = we_dat & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc <= '0;
         ien <= 1'b0;
         adr <= '0;
         cmd <= '0;
         dat <= '0;
      end else begin
         if (we_ctl) begin
            cyc <= wdata[2:0];
            ien <= wdata[CT_IEN];
         end
         if (we_adr) adr <= wdata[7:0];
         if (we_cmd) cmd <= wdata[7:0];
         if (eng_load)    dat <= eng_word;
         else if (we_dat) dat <= wdata;
      end
   end
endmodule

// File: rtl/smbh_fifo.sv
module smbh_fifo #(
   parameter int DEPTH  = 32,
   parameter int WIDTH  = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = PTR_W + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CNT_W-1:0] cnt
);
   localparam bit IS_POW2 = (DEPTH == (1 << PTR_W));

   if (DEPTH < 2) begin : g_bad_depth
      $error("smbh_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             push_ok, pop_ok;

   if (IS_POW2) begin : g_wrap_nat
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
   end

   assign push_ok = push & (cnt != CNT_W'(DEPTH));
   assign pop_ok  = pop & (cnt != '0);
   assign head    = (cnt != '0) ? mem[rd_ptr] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         cnt <= cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !clr) mem[wr_ptr] <= push_data;
   end
endmodule

// File: rtl/smbh_regfront.sv
module smbh_regfront
   import smbh_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int FIFO_DEPTH = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [15:0]       io_wdata,
   output logic [15:0]       io_rdata,
   output logic              irq,
   output logic              eng_start,
   output logic              eng_abort,
   output logic [2:0]        eng_cycle,
   output logic [7:0]        eng_addr,
   output logic [7:0]        eng_cmd,
   output logic [15:0]       eng_data,
   input  logic              eng_done,
   input  logic [3:0]        eng_err,
   input  logic              eng_data_we,
   input  logic [15:0]       eng_data_in,
   input  logic              eng_fifo_pop,
   output logic [7:0]        eng_fifo_head,
   input  logic              eng_fifo_push,
   input  logic [7:0]        eng_fifo_wdata
);
   localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("smbh_regfront: ADDR_W must cover offset 0x9");
   end

   logic hit_sts, hit_ctl, hit_adr, hit_dat, hit_cmd, hit_fifo;
   assign hit_sts  = io_addr == ADDR_W'(OFF_STS);
   assign hit_ctl  = io_addr == ADDR_W'(OFF_CTL);
   assign hit_adr  = io_addr == ADDR_W'(OFF_ADR);
   assign hit_dat  = io_addr == ADDR_W'(OFF_DAT);
   assign hit_cmd  = io_addr == ADDR_W'(OFF_CMD);
   assign hit_fifo = io_addr == ADDR_W'(OFF_FIFO);

   logic             busy;
   logic [5:0]       sts;
   logic             ien, fifo_clr;
   logic [CNT_W-1:0] fifo_cnt;
   logic             done_load;

   smbh_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .sts_we    (io_wr & hit_sts),
      .sts_wdata (io_wdata[5:0]),
      .start_req (io_wr & hit_ctl & io_wdata[CT_START]),
      .abort_req (io_wr & hit_ctl & io_wdata[CT_ABORT]),
      .done      (eng_done),
      .err       (smbh_err_t'(eng_err)),
      .busy      (busy),
      .sts       (sts),
      .start_p   (eng_start),
      .abort_p   (eng_abort)
   );

   assign done_load = eng_done & busy & eng_data_we;

   smbh_hregs #(.DATA_W(16)) u_hregs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_ctl   (io_wr & hit_ctl),
      .we_adr   (io_wr & hit_adr),
      .we_dat   (io_wr & hit_dat),
      .we_cmd   (io_wr & hit_cmd),
      .wdata    (io_wdata),
      .busy     (busy),
      .eng_load (done_load),
      .eng_word (eng_data_in),
      .cyc      (eng_cycle),
      .ien      (ien),
      .adr      (eng_addr),
      .cmd      (eng_cmd),
      .dat      (eng_data),
      .fifo_clr (fifo_clr)
   );

   smbh_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (fifo_clr),
      .push      ((io_wr & hit_fifo) | eng_fifo_push),
      .push_data (eng_fifo_push ? eng_fifo_wdata : io_wdata[7:0]),
      .pop       ((io_rd & hit_fifo) | eng_fifo_pop),
      .head      (eng_fifo_head),
      .cnt       (fifo_cnt)
   );

   assign irq = sts[ST_DONE] & ien;

   always_comb begin
      io_rdata = '0;
      if (hit_sts)  io_rdata = {10'b0, sts};
      if (hit_ctl)  io_rdata = {11'b0, ien, 1'b0, eng_cycle};
      if (hit_adr)  io_rdata = {8'b0, eng_addr};
      if (hit_dat)  io_rdata = eng_data;
      if (hit_cmd)  io_rdata = {8'b0, eng_cmd};
      if (hit_fifo) io_rdata = {8'b0, eng_fifo_head};
   end
endmodule

// File: rtl/smbh_regfront_chk.sv
module smbh_regfront_chk
   import smbh_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int FIFO_DEPTH = 32,
   localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              io_wr,
   input logic [ADDR_W-1:0] io_addr,
   input logic [15:0]       io_wdata,
   input logic              busy,
   input logic [5:0]        sts,
   input logic              eng_start,
   input logic              eng_abort,
   input logic              eng_done,
   input logic [CNT_W-1:0]  fifo_cnt
);
   logic ctl_wr;
   assign ctl_wr = io_wr && (io_addr == ADDR_W'(OFF_CTL));

   p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && io_wdata[CT_START] && !busy) |=> (busy && eng_start));

   p_no_start_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !eng_start);

   p_done_completes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && busy) |=> (!busy && sts[ST_DONE]));

   p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !eng_done) |=> busy);

   p_idle_abort_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && io_wdata[CT_ABORT] && !busy) |=> !eng_abort);

   p_fifo_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CNT_W'(FIFO_DEPTH));
endmodule

bind smbh_regfront smbh_regfront_chk #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_wr     (io_wr),
   .io_addr   (io_addr),
   .io_wdata  (io_wdata),
   .busy      (busy),
   .sts       (sts),
   .eng_start (eng_start),
   .eng_abort (eng_abort),
   .eng_done  (eng_done),
   .fifo_cnt  (fifo_cnt)
);

// File: tb/smbh_regfront_tb_top.sv
module smbh_regfront_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [3:0]  io_addr = '0;
   logic [15:0] io_wdata = '0;
   logic [15:0] io_rdata;
   logic        irq, eng_start, eng_abort;
   logic [2:0]  eng_cycle;
   logic [7:0]  eng_addr, eng_cmd, eng_fifo_head;
   logic [15:0] eng_data;
   logic        eng_done = 1'b0, eng_data_we = 1'b0;
   logic [3:0]  eng_err = '0;
   logic [15:0] eng_data_in = '0;
   logic        eng_fifo_pop = 1'b0, eng_fifo_push = 1'b0;
   logic [7:0]  eng_fifo_wdata = '0;

   int checks = 0, errors = 0, cycles = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   smbh_regfront dut_i (.*);

   // behavioural reference model
   bit       m_busy, m_ien, m_start, m_abort;
   bit [5:0] m_sts;
   byte unsigned q[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_ien = 0; m_start = 0; m_abort = 0; m_sts = 0; q.delete();
      end else begin
         automatic bit b0 = m_busy;
         automatic int sz0 = q.size();
         m_start = 0; m_abort = 0;
         if (io_wr && io_addr == 4'h0) m_sts = m_sts & ~(io_wdata[5:0] & 6'h37);
         if (io_wr && io_addr == 4'h2) begin
            m_ien = io_wdata[4];
            if (io_wdata[3] && !b0) begin m_busy = 1; m_start = 1; end
            if (io_wdata[5] && b0) m_abort = 1;
         end
         if (io_wr && io_addr == 4'h6 && !b0) q.delete();
         else begin
            if ((io_rd && io_addr == 4'h9) || eng_fifo_pop)
               if (q.size() > 0) void'(q.pop_front());
            if (eng_fifo_push) begin
               if (sz0 < 32) q.push_back(eng_fifo_wdata);
            end else if (io_wr && io_addr == 4'h9) begin
               if (sz0 < 32) q.push_back(io_wdata[7:0]);
            end
         end
         if (eng_done && b0) begin
            m_busy = 0;
            m_sts[4] = 1;
            m_sts[5] |= eng_err[3]; m_sts[2] |= eng_err[2];
            m_sts[1] |= eng_err[1]; m_sts[0] |= eng_err[0];
         end
      end
   end

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(eng_start == m_start, "R3/R4 eng_start", eng_start, m_start);
         check(eng_abort == m_abort, "R7 eng_abort", eng_abort, m_abort);
         check(irq == (m_sts[4] && m_ien), "R8 irq", irq, m_sts[4] && m_ien);
         check(eng_fifo_head == ((q.size() > 0) ? q[0] : 8'h00), "R9 head",
               eng_fifo_head, (q.size() > 0) ? q[0] : 0);
      end
   end

   task automatic wr(input bit [3:0] a, input bit [15:0] d);
      @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
      @(negedge clk); io_wr = 0;
   endtask

   task automatic rd_chk(input bit [3:0] a, input bit [15:0] exp, input string req);
      @(negedge clk); io_rd = 1; io_addr = a;
      #5 check(io_rdata == exp, req, io_rdata, exp);
      @(negedge clk); io_rd = 0;
   endtask

   task automatic peek(input bit [3:0] a, input bit [15:0] exp, input string req);
      @(negedge clk); io_addr = a;
      #5 check(io_rdata == exp, req, io_rdata, exp);
   endtask

   task automatic finish_eng(input bit [3:0] e, input bit we, input bit [15:0] din);
      @(negedge clk); eng_done = 1; eng_err = e; eng_data_we = we; eng_data_in = din;
      @(negedge clk); eng_done = 0; eng_err = 0; eng_data_we = 0;
   endtask

   task automatic eng_pop();
      @(negedge clk); eng_fifo_pop = 1;
      @(negedge clk); eng_fifo_pop = 0;
   endtask

   task automatic eng_push(input bit [7:0] d);
      @(negedge clk); eng_fifo_push = 1; eng_fifo_wdata = d;
      @(negedge clk); eng_fifo_push = 0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual %0d expected <50000 cycles", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      peek(4'h0, 16'h0000, "R1 status");
      peek(4'h2, 16'h0000, "R1 control");
      peek(4'h6, 16'h0000, "R1 data");
      peek(4'h9, 16'h0000, "R1 fifo");
      // R2 decode and engine view
      wr(4'h4, 16'h00A7); wr(4'h8, 16'h005C); wr(4'h6, 16'h1234);
      peek(4'h4, 16'h00A7, "R2 addr");
      peek(4'h8, 16'h005C, "R2 cmd");
      peek(4'h6, 16'h1234, "R2 data");
      check(eng_addr == 8'hA7 && eng_addr[0], "R2 eng_addr", eng_addr, 8'hA7);
      check(eng_cmd == 8'h5C && eng_data == 16'h1234, "R2 eng_cmd/data", eng_cmd, 8'h5C);
      // R3 start from idle
      wr(4'h2, 16'h001B);
      check(eng_cycle == 3'd3, "R3 eng_cycle", eng_cycle, 3);
      peek(4'h0, 16'h0008, "R3 busy");
      peek(4'h2, 16'h0013, "R3 control readback");
      // R4 start while busy; R6 busy survives clear
      wr(4'h2, 16'h001B);
      wr(4'h0, 16'h003F);
      peek(4'h0, 16'h0008, "R4/R6 still busy");
      // R7 abort while busy
      wr(4'h2, 16'h0033);
      peek(4'h2, 16'h0013, "R7 abort reads 0");
      // R5 completion with collision+aborted, R8 irq
      finish_eng(4'b0011, 0, 0);
      peek(4'h0, 16'h0013, "R5 status");
      check(irq == 1, "R8 irq high", irq, 1);
      // R6 partial then full clear
      wr(4'h0, 16'h0002);
      peek(4'h0, 16'h0011, "R6 partial clear");
      wr(4'h0, 16'h0011);
      peek(4'h0, 16'h0000, "R6 full clear");
      check(irq == 0, "R8 irq low", irq, 0);
      // R7 abort while idle ignored
      wr(4'h2, 16'h0020);
      peek(4'h0, 16'h0000, "R7 idle abort");
      // R9 host push, engine pop
      wr(4'h6, 16'h0003);
      wr(4'h9, 16'h0011); wr(4'h9, 16'h0022); wr(4'h9, 16'h0033);
      check(eng_fifo_head == 8'h11, "R9 head first", eng_fifo_head, 8'h11);
      eng_pop(); check(eng_fifo_head == 8'h22, "R9 head second", eng_fifo_head, 8'h22);
      eng_pop(); eng_pop();
      check(eng_fifo_head == 8'h00, "R10 empty head", eng_fifo_head, 0);
      // R10 overflow
      wr(4'h6, 16'h0020);
      for (int i = 0; i < 40; i++) wr(4'h9, 16'(i + 1));
      for (int i = 0; i < 32; i++) begin
         check(eng_fifo_head == 8'(i + 1), "R10 order", eng_fifo_head, i + 1);
         eng_pop();
      end
      rd_chk(4'h9, 16'h0000, "R10 empty pop");
      check(eng_fifo_head == 8'h00, "R10 still empty", eng_fifo_head, 0);
      // R11 block read
      wr(4'h2, 16'h000D);
      eng_push(8'hAA); eng_push(8'hBB); eng_push(8'hCC); eng_push(8'hDD);
      finish_eng(4'b0000, 1, 16'h0004);
      peek(4'h6, 16'h0004, "R11 length");
      rd_chk(4'h9, 16'h00AA, "R11 byte0");
      rd_chk(4'h9, 16'h00BB, "R11 byte1");
      rd_chk(4'h9, 16'h00CC, "R11 byte2");
      rd_chk(4'h9, 16'h00DD, "R11 byte3");
      rd_chk(4'h9, 16'h0000, "R11 drained");
      peek(4'h0, 16'h0010, "R5 clean done");
      // R9 data write while busy keeps FIFO; R5 timeout+protocol
      wr(4'h0, 16'h0010);
      wr(4'h2, 16'h0008);
      wr(4'h9, 16'h0077);
      wr(4'h6, 16'h0001);
      check(eng_fifo_head == 8'h77, "R9 busy data write", eng_fifo_head, 8'h77);
      finish_eng(4'b1100, 0, 0);
      peek(4'h0, 16'h0034, "R5 tmo+prot");
      wr(4'h0, 16'h003F);
      peek(4'h0, 16'h0000, "R6 clear all");
      repeat (2) @(negedge clk);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule